// File: doc/BRIEF.md
# Calendar Time Validator and BCD Packer

The block takes a calendar date and time held in binary: a full four-digit year, a month, a day of the month, hours, minutes and seconds. It decides in one step whether the value is a legal calendar value inside a fixed hundred-year window. Any field that is out of range fails the check, and so does a day past the end of its month. February is given its extra day under the full Gregorian leap rule.

One cycle after a request it reports a pass or fail result. When the value passes, it folds the year into two digits, packs every field as two-digit BCD and sends six register writes to a clock chip in a fixed order. When the value fails, it sends nothing.

A separate readback path takes one BCD field read back from the chip and returns its binary value. A two-digit year in the lower part of the window is placed in the later century, so the result counts years since 1900. A month is returned counted from zero.

Top module: `caltime_packer`

## Requirements
- R1: A year below 1970 or above 2069 fails the check, and both 1970 and 2069 pass.
- R2: A month of 0 or a month above 12 fails the check.
- R3: A day of 0 fails the check. A day greater than the month's length also fails: 31 days for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 for month 2 in a common year.
- R4: A year divisible by 400, or divisible by 4 but not by 100, is a leap year, and its month 2 allows day 29. Any other year fails on February 29.
- R5: Hours of 24 or more, minutes of 60 or more and seconds of 60 or more each fail the check.
- R6: A request accepted at a clock edge makes `res_valid` high for exactly the next cycle. In that cycle `res_err` is 1 on a failed check and 0 on a pass. A failed check produces no write.
- R7: The two-digit year written is the full year minus 2000 for years 2000 and later, and the full year minus 1900 otherwise. Every written field is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R8: A passing request writes six words on six consecutive cycles, and the first word is in the same cycle as `res_valid`. The field codes on `wr_sel` run in this order: 0 year, 1 month, 2 day, 3 hours, 4 minutes, 5 seconds.
- R9: While `wr_valid` is high, `set_valid` is ignored: no result is produced and the write stream in progress is not altered.
- R10: A readback request makes `rbk_valid` high one cycle later, with `rbk_sel` equal to `rd_sel` and `rbk_value` equal to 10×tens+units. For code 0 (year), a value of 69 or less has 100 added. For code 1 (month), the value is reduced by one. Codes 2 to 5 are returned unchanged.
- R11: During reset, `res_valid`, `wr_valid` and `rbk_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_valid | input | 1 | Request to check and pack the date and time inputs |
| set_year | input | 12 | Full year in binary |
| set_month | input | 4 | Month, 1 to 12 when legal |
| set_day | input | 5 | Day of month |
| set_hour | input | 5 | Hours, 0 to 23 when legal |
| set_min | input | 6 | Minutes, 0 to 59 when legal |
| set_sec | input | 6 | Seconds, 0 to 59 when legal |
| rd_valid | input | 1 | Readback field present |
| rd_sel | input | 3 | Field code of the readback field |
| rd_bcd | input | 8 | BCD value read back from the chip |
| res_valid | output | 1 | Check result present |
| res_err | output | 1 | 1 when the check failed |
| wr_valid | output | 1 | Register write present |
| wr_sel | output | 3 | Field code of the write |
| wr_data | output | 8 | BCD data of the write |
| rbk_valid | output | 1 | Readback result present |
| rbk_sel | output | 3 | Field code of the readback result |
| rbk_value | output | 8 | Binary readback value |

## Verification
The assertions check the structure of the stream on every cycle. The field codes must step without gaps and end after code 5. A pass must start the stream in the result cycle, and a fail must never coincide with a write. Every written digit must be a legal BCD digit, no result may appear while a stream is running, and the readback latency is fixed. Whether a given date is judged correctly can only be shown by the bench scenarios. That covers the window edges, leap and non-leap Februaries, 30-day months and the time limits, along with the actual written values, the year folding and the readback offsets.

// File: rtl/caltime_packer.sv
module caltime_packer #(
  parameter int YEAR_W    = 12,
  parameter int BASE_YEAR = 1970,
  parameter int SPAN      = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [YEAR_W-1:0] set_year,
  input  logic [3:0]        set_month,
  input  logic [4:0]        set_day,
  input  logic [4:0]        set_hour,
  input  logic [5:0]        set_min,
  input  logic [5:0]        set_sec,
  input  logic              rd_valid,
  input  logic [2:0]        rd_sel,
  input  logic [7:0]        rd_bcd,
  output logic              res_valid,
  output logic              res_err,
  output logic              wr_valid,
  output logic [2:0]        wr_sel,
  output logic [7:0]        wr_data,
  output logic              rbk_valid,
  output logic [2:0]        rbk_sel,
  output logic [7:0]        rbk_value
);
  localparam int LAST_YEAR = BASE_YEAR + SPAN - 1;
  localparam int CENT      = (LAST_YEAR / 100) * 100;
  localparam int WRAP      = LAST_YEAR % 100;
  localparam int NF        = 6;
  localparam logic [2:0] LAST_SEL = 3'(NF - 1);

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] t;
    t = v / 7'd10;
    return {t[3:0], 4'(v - t * 7'd10)};
  endfunction

  logic       leap, yr_ok, mo_ok, dy_ok, tm_ok, all_ok, accept;
  logic [4:0] mdays;
  logic [6:0] yy;
  logic [NF-1:0][7:0] fld_q;

  assign leap = (((set_year % YEAR_W'(4)) == '0) && ((set_year % YEAR_W'(100)) != '0))
              || ((set_year % YEAR_W'(400)) == '0);

  always_comb begin
    case (set_month)
      4'd2:                    mdays = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: mdays = 5'd30;
      default:                 mdays = 5'd31;
    endcase
  end

  assign yr_ok  = (set_year >= YEAR_W'(BASE_YEAR)) && (set_year <= YEAR_W'(LAST_YEAR));
  assign mo_ok  = (set_month != 4'd0) && (set_month <= 4'd12);
  assign dy_ok  = (set_day != 5'd0) && (set_day <= mdays);
  assign tm_ok  = (set_hour < 5'd24) && (set_min < 6'd60) && (set_sec < 6'd60);
  assign all_ok = yr_ok && mo_ok && dy_ok && tm_ok;
  assign accept = set_valid && !wr_valid;
  assign yy     = (set_year >= YEAR_W'(CENT)) ? 7'(set_year - YEAR_W'(CENT))
                                              : 7'(set_year - YEAR_W'(CENT - 100));
  assign wr_data = fld_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      wr_valid  <= 1'b0;
      wr_sel    <= 3'd0;
      fld_q     <= '0;
    end else begin
      res_valid <= accept;
      if (accept) res_err <= !all_ok;
      if (accept && all_ok) begin
        wr_valid <= 1'b1;
        wr_sel   <= 3'd0;
        fld_q    <= {to_bcd({1'b0, set_sec}), to_bcd({1'b0, set_min}),
                     to_bcd({2'b0, set_hour}), to_bcd({2'b0, set_day}),
                     to_bcd({3'b0, set_month}), to_bcd(yy)};
      end else if (wr_valid) begin
        fld_q  <= {8'h00, fld_q[NF-1:1]};
        wr_sel <= (wr_sel == LAST_SEL) ? 3'd0 : wr_sel + 3'd1;
        if (wr_sel == LAST_SEL) wr_valid <= 1'b0;
      end
    end
  end

  logic [6:0] rb_bin;
  assign rb_bin = 7'(rd_bcd[7:4]) * 7'd10 + 7'(rd_bcd[3:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbk_valid <= 1'b0;
      rbk_sel   <= 3'd0;
      rbk_value <= 8'd0;
    end else begin
      rbk_valid <= rd_valid;
      if (rd_valid) begin
        rbk_sel <= rd_sel;
        case (rd_sel)
          3'd0:    rbk_value <= (rb_bin <= 7'(WRAP)) ? {1'b0, rb_bin} + 8'd100 : {1'b0, rb_bin};
          3'd1:    rbk_value <= {1'b0, rb_bin} - 8'd1;
          default: rbk_value <= {1'b0, rb_bin};
        endcase
      end
    end
  end

  assert_stream_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel != LAST_SEL) |=> (wr_valid && wr_sel == 3'($past(wr_sel) + 3'd1)));
  assert_stream_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == LAST_SEL) |=> !wr_valid);
  assert_pass_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (wr_valid && wr_sel == 3'd0));
  assert_fail_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> !wr_valid);
  assert_bcd_digits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[7:4] <= 4'd9 && wr_data[3:0] <= 4'd9));
  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !res_valid);
  assert_rbk_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rbk_valid);
  assert_rbk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rbk_valid);
endmodule

// File: tb/tb_caltime_packer.sv
module tb_caltime_packer;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_valid = 1'b0;
  logic [11:0] set_year = '0;
  logic [3:0] set_month = '0;
  logic [4:0] set_day = '0, set_hour = '0;
  logic [5:0] set_min = '0, set_sec = '0;
  logic rd_valid = 1'b0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_bcd = '0;
  logic res_valid, res_err, wr_valid, rbk_valid;
  logic [2:0] wr_sel, rbk_sel;
  logic [7:0] wr_data, rbk_value;

  int checks = 0, failures = 0;
  bit    exp_err_q[$];
  string exp_tag_q[$];
  logic [10:0] exp_wr_q[$];
  logic [10:0] exp_rb_q[$];

  always #(CLK_P/2) clk = ~clk;

  caltime_packer dut (
    .clk, .rst_n, .set_valid, .set_year, .set_month, .set_day, .set_hour,
    .set_min, .set_sec, .rd_valid, .rd_sel, .rd_bcd, .res_valid, .res_err,
    .wr_valid, .wr_sel, .wr_data, .rbk_valid, .rbk_sel, .rbk_value);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mlen(int y, int m);
    bit lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic send(int y, int mo, int d, int h, int mi, int s, string tag);
    bit ok;
    ok = (y >= 1970) && (y <= 2069) && (mo >= 1) && (mo <= 12) && (d >= 1)
         && (h < 24) && (mi < 60) && (s < 60);
    if (ok) ok = d <= mlen(y, mo);
    @(negedge clk);
    set_year = 12'(y); set_month = 4'(mo); set_day = 5'(d);
    set_hour = 5'(h); set_min = 6'(mi); set_sec = 6'(s);
    set_valid = 1'b1;
    exp_err_q.push_back(!ok);
    exp_tag_q.push_back(tag);
    if (ok) begin
      exp_wr_q.push_back({3'd0, bcd(y >= 2000 ? y - 2000 : y - 1900)});
      exp_wr_q.push_back({3'd1, bcd(mo)});
      exp_wr_q.push_back({3'd2, bcd(d)});
      exp_wr_q.push_back({3'd3, bcd(h)});
      exp_wr_q.push_back({3'd4, bcd(mi)});
      exp_wr_q.push_back({3'd5, bcd(s)});
    end
    @(negedge clk);
    set_valid = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic rdback(int sel, logic [7:0] b, int val);
    @(negedge clk);
    rd_valid = 1'b1; rd_sel = 3'(sel); rd_bcd = b;
    exp_rb_q.push_back({3'(sel), 8'(val)});
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (res_valid) begin
      if (exp_err_q.size() == 0) chk("R9 unexpected result", 1, 0);
      else chk({exp_tag_q.pop_front(), " result err flag"}, int'(res_err), int'(exp_err_q.pop_front()));
    end
    if (wr_valid) begin
      if (exp_wr_q.size() == 0) chk("R6 unexpected write", 1, 0);
      else chk("R7 R8 write sel/data", int'({wr_sel, wr_data}), int'(exp_wr_q.pop_front()));
    end
    if (rbk_valid) begin
      if (exp_rb_q.size() == 0) chk("R10 unexpected readback", 1, 0);
      else chk("R10 readback sel/value", int'({rbk_sel, rbk_value}), int'(exp_rb_q.pop_front()));
    end
  end

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 res_valid in reset", int'(res_valid), 0);
    chk("R11 wr_valid in reset", int'(wr_valid), 0);
    chk("R11 rbk_valid in reset", int'(rbk_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(2024, 2, 29, 12, 34, 56, "R4 leap 2024");
    send(1999, 12, 31, 23, 59, 59, "R7 year 1999");
    send(1970, 1, 1, 0, 0, 0, "R1 low edge");
    send(2069, 6, 15, 7, 8, 9, "R1 high edge");
    send(1969, 12, 31, 23, 59, 59, "R1 below window");
    send(2070, 1, 1, 0, 0, 0, "R1 above window");
    send(2010, 0, 10, 1, 1, 1, "R2 month zero");
    send(2010, 13, 10, 1, 1, 1, "R2 month 13");
    send(2010, 5, 0, 1, 1, 1, "R3 day zero");
    send(2023, 4, 31, 1, 1, 1, "R3 april 31");
    send(2023, 4, 30, 1, 1, 1, "R3 april 30");
    send(2023, 1, 31, 1, 1, 1, "R3 january 31");
    send(2023, 2, 29, 1, 1, 1, "R4 common feb 29");
    send(2023, 2, 28, 1, 1, 1, "R3 common feb 28");
    send(2000, 2, 29, 5, 5, 5, "R4 year 2000");
    send(2010, 3, 3, 24, 0, 0, "R5 hour 24");
    send(2010, 3, 3, 0, 60, 0, "R5 minute 60");
    send(2010, 3, 3, 0, 0, 60, "R5 second 60");
    send(2010, 3, 3, 23, 59, 59, "R5 max time");

    // R9: requests during a running stream must vanish
    @(negedge clk);
    set_year = 12'd2045; set_month = 4'd11; set_day = 5'd22;
    set_hour = 5'd13; set_min = 6'd14; set_sec = 6'd15; set_valid = 1'b1;
    exp_err_q.push_back(1'b0); exp_tag_q.push_back("R9 base request");
    exp_wr_q.push_back({3'd0, 8'h45}); exp_wr_q.push_back({3'd1, 8'h11});
    exp_wr_q.push_back({3'd2, 8'h22}); exp_wr_q.push_back({3'd3, 8'h13});
    exp_wr_q.push_back({3'd4, 8'h14}); exp_wr_q.push_back({3'd5, 8'h15});
    @(negedge clk);
    set_year = 12'd2050; set_month = 4'd1; set_day = 5'd2; set_hour = 5'd3;
    set_min = 6'd4; set_sec = 6'd5;
    repeat (3) @(negedge clk);
    set_month = 4'd14;
    @(negedge clk);
    set_valid = 1'b0;
    repeat (6) @(negedge clk);

    rdback(0, 8'h69, 169);
    rdback(0, 8'h70, 70);
    rdback(0, 8'h00, 100);
    rdback(0, 8'h99, 99);
    rdback(1, 8'h12, 11);
    rdback(1, 8'h01, 0);
    rdback(2, 8'h31, 31);
    rdback(5, 8'h59, 59);
    repeat (3) @(negedge clk);

    chk("R6 results left over", exp_err_q.size(), 0);
    chk("R8 writes left over", exp_wr_q.size(), 0);
    chk("R10 readbacks left over", exp_rb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule